// File: doc/BRIEF.md
# Prioritised Interrupt Routing Controller

This block collects up to 32 level-sensitive interrupt lines and routes them to a small set of processor contexts. Each context owns an enable mask, a priority threshold and a claim/complete word. Every source has a small priority value that is shared by all contexts. A context's request line stays high while at least one source is pending, enabled for that context, and has a priority above the context's threshold.

Software services an interrupt in two steps. It first reads the context's claim word. The read returns the winning source ID and takes ownership of that source. After handling the source, software writes the same ID back to the claim word to release it. A claimed source cannot become pending again until that release write arrives. ID 0 is reserved to mean "nothing to service". All registers are reached through a simple 32-bit word bus that has a write enable, a read strobe and registered read data.

Top module: `irq_hub`

## Requirements
- R1: Source IDs run from 1 to NUM_SRC-1. ID 0 is never pending. A claim read returns 0 when no source qualifies for that context.
- R2: The priority of source n is the word at byte address 4*n. Only its low 3 bits are stored, and bits 31..3 read as 0. The word for ID 0 always reads 0 and ignores writes.
- R3: The enable word of context h is at 0x2000 + 0x80*h. Bit n enables source n, and bit 0 always reads 0.
- R4: The threshold of context h is at 0x200000 + 0x1000*h. It is 3 bits wide, and the upper bits read as 0.
- R5: A claim read at 0x200000 + 0x1000*h + 4 returns the ID of the enabled pending source with the highest priority strictly above the threshold. When priorities tie, the lowest ID wins.
- R6: A source with priority 0 never raises a request or wins a claim. A threshold of 0 admits every nonzero priority.
- R7: A claim read that returns a nonzero ID clears that source's pending state. The source cannot become pending again until it is completed, even while its line stays high.
- R8: Writing a claimed ID to any claim word releases it, and a high line then makes it pending again one cycle later. Writing an ID that is not currently claimed changes nothing.
- R9: irq_o[h] is high exactly when some pending source enabled for h has a priority strictly greater than threshold h. It reflects the register state with no added delay.
- R10: bus_rdata is loaded on the clock edge where bus_re is high and holds its value otherwise. An address that maps to no register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level interrupt lines, bit n is source n |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe (claim reads have side effects) |
| bus_rdata | output | 32 | Read data, valid after the edge that sampled bus_re |
| irq_o | output | NUM_CTX | Per-context interrupt request |

## Verification
Lines and register writes are taken at one clock edge. The pending, claimed and configuration state changes at that edge, and irq_o follows the new state combinationally, so the bench drives inputs on the falling edge and checks irq_o on the next falling edge. Read data is registered on the edge that samples bus_re, so the bench compares each read one falling edge after it raised the strobe. A bench model advances its pending and claimed sets in the same edge order, with claims taken before lines are merged. Every check therefore lands on the cycle where the requirement says the result is due.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_re,
  output logic [31:0]         bus_rdata,
  output logic [NUM_CTX-1:0]  irq_o
);
  localparam int ID_W  = $clog2(NUM_SRC);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(NUM_SRC * 4);
  localparam logic [ADDR_W-1:0] EN_BASE  = ADDR_W'(32'h2000);
  localparam logic [ADDR_W-1:0] EN_SPAN  = ADDR_W'(NUM_CTX * 128);
  localparam logic [ADDR_W-1:0] CX_BASE  = ADDR_W'(32'h20_0000);
  localparam logic [ADDR_W-1:0] CX_SPAN  = ADDR_W'(NUM_CTX * 4096);
  localparam logic [NUM_SRC-1:0] SRC_MASK = {{(NUM_SRC-1){1'b1}}, 1'b0};

  logic [PRIO_W-1:0]  prio_q [NUM_SRC];
  logic [NUM_SRC-1:0] en_q   [NUM_CTX];
  logic [PRIO_W-1:0]  thr_q  [NUM_CTX];
  logic [NUM_SRC-1:0] pend_q, clm_q;
  logic [ID_W-1:0]    best_id [NUM_CTX];
  logic [NUM_CTX-1:0] arb_hit;

  logic [ADDR_W-1:0] en_off, cx_off;
  logic              is_prio, is_en, is_cx, is_thr, is_clm;
  logic [ID_W-1:0]   prio_idx, claim_id, done_id;
  logic [CTX_W-1:0]  en_ctx, cx_ctx;
  logic [NUM_SRC-1:0] claim_mask, done_mask;
  logic              done_ok;
  logic [31:0]       rd_val;

  assign en_off   = bus_addr - EN_BASE;
  assign cx_off   = bus_addr - CX_BASE;
  assign is_prio  = (bus_addr < PRIO_END) && (bus_addr[1:0] == 2'b00);
  assign is_en    = (bus_addr >= EN_BASE) && (en_off < EN_SPAN) && (en_off[6:0] == 7'd0);
  assign is_cx    = (bus_addr >= CX_BASE) && (cx_off < CX_SPAN);
  assign is_thr   = is_cx && (cx_off[11:0] == 12'h000);
  assign is_clm   = is_cx && (cx_off[11:0] == 12'h004);
  assign prio_idx = bus_addr[ID_W+1:2];
  assign en_ctx   = en_off[CTX_W+6:7];
  assign cx_ctx   = cx_off[CTX_W+11:12];

  // Per-context arbiter: strict compare keeps the lowest ID on ties
  always_comb begin
    for (int h = 0; h < NUM_CTX; h++) begin
      logic [PRIO_W-1:0] bp;
      logic [ID_W-1:0]   bi;
      bp = thr_q[h];
      bi = '0;
      for (int n = 1; n < NUM_SRC; n++) begin
        if (pend_q[n] && en_q[h][n] && (prio_q[n] > bp)) begin
          bp = prio_q[n];
          bi = ID_W'(n);
        end
      end
      best_id[h] = bi;
      arb_hit[h] = (bi != '0);
    end
  end

  // Request lines from a flat compare, independent of the arbiter chain
  always_comb begin
    for (int h = 0; h < NUM_CTX; h++) begin
      logic [NUM_SRC-1:0] above;
      for (int n = 0; n < NUM_SRC; n++) above[n] = (prio_q[n] > thr_q[h]);
      irq_o[h] = |(pend_q & en_q[h] & above);
    end
  end

  assign claim_id   = best_id[cx_ctx];
  assign claim_mask = (bus_re && is_clm) ? ((NUM_SRC'(1) << claim_id) & SRC_MASK) : '0;
  assign done_id    = bus_wdata[ID_W-1:0];
  assign done_ok    = bus_we && is_clm && (bus_wdata < 32'(NUM_SRC)) && clm_q[done_id];
  assign done_mask  = done_ok ? (NUM_SRC'(1) << done_id) : '0;

  always_comb begin
    rd_val = '0;
    if (is_prio)     rd_val = 32'(prio_q[prio_idx]);
    else if (is_en)  rd_val = 32'(en_q[en_ctx]);
    else if (is_thr) rd_val = 32'(thr_q[cx_ctx]);
    else if (is_clm) rd_val = 32'(claim_id);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_SRC; n++) prio_q[n] <= '0;
      for (int h = 0; h < NUM_CTX; h++) begin
        en_q[h]  <= '0;
        thr_q[h] <= '0;
      end
      pend_q    <= '0;
      clm_q     <= '0;
      bus_rdata <= '0;
    end else begin
      pend_q <= (pend_q | (src_i & ~clm_q & SRC_MASK)) & ~claim_mask;
      clm_q  <= (clm_q | claim_mask) & ~done_mask;
      if (bus_we && is_prio && (prio_idx != '0)) prio_q[prio_idx] <= bus_wdata[PRIO_W-1:0];
      if (bus_we && is_en)  en_q[en_ctx]  <= bus_wdata[NUM_SRC-1:0] & SRC_MASK;
      if (bus_we && is_thr) thr_q[cx_ctx] <= bus_wdata[PRIO_W-1:0];
      if (bus_re) bus_rdata <= rd_val;
    end
  end

  p_id0_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0] && !clm_q[0]);
  p_prio_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && is_prio |=> bus_rdata[31:PRIO_W] == '0);
  p_arb_vs_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_hit == irq_o);
  p_claim_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && is_clm && (claim_id != '0) |=> !pend_q[$past(claim_id)] && clm_q[$past(claim_id)]);
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & clm_q) == '0);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok && !(bus_re && is_clm) |=> !clm_q[$past(done_id)]);
  p_stray_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && is_clm && !done_ok |=> clm_q == ($past(clm_q) | $past(claim_mask)));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && !(is_prio || is_en || is_thr || is_clm) |=> bus_rdata == '0);
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/irq_hub_tb_top.sv
module irq_hub_tb_top;
  localparam int NS = 32;
  localparam int NC = 2;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_i = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_re = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_o;

  irq_hub #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0]    m_prio [NS];
  logic [NS-1:0] m_en   [NC];
  logic [2:0]    m_thr  [NC];
  logic [NS-1:0] m_pend, m_clm;
  logic [31:0]   m_rd;

  function automatic logic [AW-1:0] a_prio(int n); return AW'(4 * n); endfunction
  function automatic logic [AW-1:0] a_en(int h);   return AW'(32'h2000 + 32'h80 * h); endfunction
  function automatic logic [AW-1:0] a_thr(int h);  return AW'(32'h20_0000 + 32'h1000 * h); endfunction
  function automatic logic [AW-1:0] a_clm(int h);  return AW'(32'h20_0004 + 32'h1000 * h); endfunction

  function automatic int m_best(int h);
    int bi = 0;
    int bp = int'(m_thr[h]);
    for (int n = 1; n < NS; n++)
      if (m_pend[n] && m_en[h][n] && int'(m_prio[n]) > bp) begin bp = int'(m_prio[n]); bi = n; end
    return bi;
  endfunction

  function automatic int m_rdval(logic [AW-1:0] a);
    for (int n = 0; n < NS; n++) if (a == a_prio(n)) return int'(m_prio[n]);
    for (int h = 0; h < NC; h++) begin
      if (a == a_en(h))  return int'(m_en[h]);
      if (a == a_thr(h)) return int'(m_thr[h]);
      if (a == a_clm(h)) return m_best(h);
    end
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [NS-1:0] cmask = '0;
    logic [NS-1:0] dmask = '0;
    if (bus_re) m_rd = 32'(m_rdval(bus_addr));
    for (int h = 0; h < NC; h++) begin
      if (bus_re && bus_addr == a_clm(h) && m_best(h) != 0) cmask[m_best(h)] = 1'b1;
      if (bus_we && bus_addr == a_clm(h) && bus_wdata < NS && m_clm[bus_wdata[4:0]])
        dmask[bus_wdata[4:0]] = 1'b1;
    end
    if (bus_we) begin
      for (int n = 1; n < NS; n++) if (bus_addr == a_prio(n)) m_prio[n] = bus_wdata[2:0];
      for (int h = 0; h < NC; h++) begin
        if (bus_addr == a_en(h))  m_en[h]  = bus_wdata & 32'hFFFF_FFFE;
        if (bus_addr == a_thr(h)) m_thr[h] = bus_wdata[2:0];
      end
    end
    m_pend = (m_pend | (src_i & ~m_clm & 32'hFFFF_FFFE)) & ~cmask;
    m_clm  = (m_clm | cmask) & ~dmask;
  endtask

  // R9: request lines checked after every edge
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    bus_we = 1'b0;
    bus_re = 1'b0;
    for (int h = 0; h < NC; h++) chk("R9 irq", 32'(irq_o[h]), 32'(m_best(h) != 0));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
  endtask

  task automatic rd(string req, logic [AW-1:0] a);
    bus_addr = a; bus_re = 1'b1;
    tick();
    chk(req, bus_rdata, m_rd);
  endtask

  task automatic rd_exp(string req, logic [AW-1:0] a, logic [31:0] e);
    rd(req, a);
    chk(req, bus_rdata, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    for (int n = 0; n < NS; n++) m_prio[n] = '0;
    for (int h = 0; h < NC; h++) begin m_en[h] = '0; m_thr[h] = '0; end
    m_pend = '0; m_clm = '0; m_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk("R9 reset irq", 32'(irq_o), 32'd0);
    chk("R10 reset rdata", bus_rdata, 32'd0);
    rd_exp("R1 empty claim", a_clm(0), 32'd0);
    rd_exp("R10 unmapped", AW'(32'h1000), 32'd0);
    wr(a_prio(3), 32'hFFFF_FFFF);
    rd_exp("R2 prio width", a_prio(3), 32'd7);
    wr(a_prio(0), 32'd5);
    rd_exp("R2 id0 prio", a_prio(0), 32'd0);
    wr(a_en(0), 32'hFFFF_FFFF);
    rd_exp("R3 enable bit0", a_en(0), 32'hFFFF_FFFE);
    rd_exp("R10 gap in enable", a_en(0) + AW'(4), 32'd0);
    rd_exp("R3 ctx1 enable", a_en(1), 32'd0);
    src_i = 32'h0000_0011;
    tick();
    chk("R6 prio0 silent", 32'(irq_o[0]), 32'd0);
    chk("R1 id0 line ignored", 32'(irq_o), 32'd0);
    rd_exp("R6 prio0 claim", a_clm(0), 32'd0);
    src_i = 32'h0000_0058;
    tick();
    chk("R6 thr0 passes", 32'(irq_o[0]), 32'd1);
    wr(a_prio(6), 32'd7);
    rd_exp("R5 tie lowest", a_clm(0), 32'd3);
    rd_exp("R5 next", a_clm(0), 32'd6);
    rd_exp("R7 held", a_clm(0), 32'd0);
    chk("R7 irq low", 32'(irq_o[0]), 32'd0);
    wr(a_clm(0), 32'd7);
    wr(a_clm(0), 32'd40);
    rd_exp("R8 stray ignored", a_clm(0), 32'd0);
    wr(a_clm(1), 32'd3);
    tick();
    rd_exp("R8 released", a_clm(0), 32'd3);
    wr(a_clm(0), 32'd6);
    wr(a_en(1), 32'h0000_0040);
    wr(a_thr(1), 32'hFFFF_FFFF);
    rd_exp("R4 thr width", a_thr(1), 32'd7);
    chk("R4 thr blocks", 32'(irq_o[1]), 32'd0);
    wr(a_thr(1), 32'd6);
    chk("R4 thr admits", 32'(irq_o[1]), 32'd1);
    rd_exp("R5 ctx1 claim", a_clm(1), 32'd6);
    wr(a_clm(0), 32'd3);
    wr(a_clm(1), 32'd6);

    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      int h  = $urandom_range(0, NC - 1);
      if ($urandom_range(0, 3) == 0) src_i = $urandom();
      case (op)
        0: wr(a_prio($urandom_range(0, NS - 1)), $urandom());
        1: wr(a_en(h), $urandom());
        2: wr(a_thr(h), $urandom_range(0, 4));
        3, 4, 5: rd("R5 R7 random claim", a_clm(h));
        6, 7: begin
          int id = $urandom_range(0, NS - 1);
          for (int n = 1; n < NS; n++) if (m_clm[n] && $urandom_range(0, 1) == 1) id = n;
          wr(a_clm(h), 32'(id));
        end
        8: rd("R2 R3 R4 random read", (op == 8 && i % 2 == 0) ? a_prio($urandom_range(0, NS - 1)) :
              (i % 3 == 0 ? a_en(h) : a_thr(h)));
        default: tick();
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule